// File: doc/BRIEF.md
# Wireless MAC Interrupt Reason and Mask Unit

This block collects interrupt causes for a wireless MAC and presents them to host software through a small register window. Internal sources pulse event lines, and each pulse sets the matching bit in a 32-bit generic reason register or in one of four per-queue reason registers. A 32-bit enable mask gates the generic causes. The block drives one level-sensitive interrupt line that is high while any gated cause is pending.

Software handles an interrupt in three steps. It reads a reason register and ANDs the value with the enable mask, or with the queue's fixed set of implemented bits. It then writes that result back to the same offset. Each 1 written clears the matching bit, so a write-back acknowledges exactly the causes that were handled. To disable all interrupts, software saves the mask and writes zero. To re-enable them, it writes the saved value back.

Two cause bits have special rules. A fatal-error cause cannot be acknowledged and stays set until reset. While generic bit 8 is clear, bit 16 of a queue reason register follows bit 0 of that queue's receive-control word.

Top module: `irq_reason_ctrl`

## Requirements
- R1: After reset, the generic reason, enable mask and all four queue reason registers read 0, and `irq` is low.
- R2: Reads are combinational and use these offsets: generic reason 0x128, enable mask 0x12C, queues 0 to 3 at 0x20, 0x28, 0x30 and 0x38. Any other offset reads 0, and writes to it change no register.
- R3: A 1 on `gen_evt[b]` sets generic bit b at the next clock edge. Writing 1s to 0x128 clears those bits. When an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R4: Generic bit 11 (fatal error) is sticky: once set, no write clears it, and only reset returns it to 0.
- R5: A write to 0x12C loads the whole enable mask. `irq` is the OR of (generic reason AND mask) and every queue reason, registered one cycle after the registers. With a zero mask and no queue cause pending, `irq` is low.
- R6: The queue implemented-bit masks are 0x1DC00 for queues 0 and 3, and 0xDC00 for queues 1 and 2. Events on the slice `q_evt[32*i +: 32]` set only implemented bits. Unimplemented bits read 0. Writing 1s to a queue offset clears the matching implemented bits.
- R7: A pending implemented queue bit raises `irq` whatever the generic enable mask holds.
- R8: While generic bit 8 is 0, bit 16 of queues 0 and 3 is forced each cycle to `rx_ctl[i]`. This override takes priority over both events and clearing writes. While bit 8 is 1, bit 16 holds its value and obeys events and clears like any other bit.
- R9: When parameter CORE_REV is below 5, a pulse on `last_rx_done` sets generic bit 29 (transmit status) at the next edge. With CORE_REV of 5 or above, that input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Register byte offset |
| wr_en | input | 1 | Write strobe for the offset on `addr` |
| wdata | input | 32 | Write data (write-one-to-clear on reason offsets) |
| rdata | output | 32 | Read data for the offset on `addr` |
| gen_evt | input | 32 | Event pulses setting generic reason bits |
| q_evt | input | 128 | Event pulses for the queue reason registers, 32 bits per queue |
| rx_ctl | input | 4 | Bit 0 of each queue's receive-control word |
| last_rx_done | input | 1 | Receive-done pulse from the last queue |
| irq | output | 1 | Level interrupt request |

## Verification
A lost or stuck reason bit shows up on `rdata` in the first read after the clock edge that should have changed it. It also shows up on `irq` one cycle after that. A wrong collision priority or a wrong sticky fatal bit therefore shows in the read that directly follows the write. A corrupted enable mask or queue implemented mask shows up as an `irq` level that disagrees with the pending causes two cycles after the stimulus. A broken bit-16 override is visible as queue 0 or queue 3 failing to follow `rx_ctl`, or failing to hold once bit 8 is set.

// File: rtl/irq_reason_ctrl.sv
module irq_reason_ctrl #(
  parameter int CORE_REV = 4,
  parameter int AW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [31:0]   gen_evt,
  input  logic [127:0]  q_evt,
  input  logic [3:0]    rx_ctl,
  input  logic          last_rx_done,
  output logic          irq
);
  localparam int NQ = 4;
  localparam logic [AW-1:0] OFS_GEN  = AW'('h128);
  localparam logic [AW-1:0] OFS_MASK = AW'('h12C);
  localparam int FATAL = 11;
  localparam int WA_EN = 8;
  localparam int WA_Q  = 16;
  localparam int TXST  = 29;

  function automatic logic [31:0] impl_mask(int i);
    return (i == 0 || i == NQ-1) ? 32'h0001_DC00 : 32'h0000_DC00;
  endfunction

  function automatic logic [AW-1:0] q_ofs(int i);
    return AW'('h20 + 8*i);
  endfunction

  logic [31:0]       gen_q, mask_q, gen_clr, tx_alias;
  logic [32*NQ-1:0]  q_flat;

  assign gen_clr = (wr_en && addr == OFS_GEN) ? wdata : 32'h0;

  if (CORE_REV < 5) begin : g_alias
    assign tx_alias = last_rx_done ? (32'h1 << TXST) : 32'h0;
  end else begin : g_noalias
    assign tx_alias = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q  <= '0;
      mask_q <= '0;
    end else begin
      gen_q <= (gen_q & ~gen_clr) | gen_evt | tx_alias | (gen_q & (32'h1 << FATAL));
      if (wr_en && addr == OFS_MASK) mask_q <= wdata;
    end
  end

  for (genvar i = 0; i < NQ; i++) begin : g_q
    localparam logic [31:0] IMPL = impl_mask(i);
    logic [31:0] r, nxt;
    always_comb begin
      nxt = (r & ~((wr_en && addr == q_ofs(i)) ? wdata : 32'h0)) | q_evt[32*i +: 32];
      if (!gen_q[WA_EN] && IMPL[WA_Q]) nxt[WA_Q] = rx_ctl[i];
      nxt = nxt & IMPL;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) r <= '0;
      else        r <= nxt;
    end
    assign q_flat[32*i +: 32] = r;
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_GEN)  rdata = gen_q;
    if (addr == OFS_MASK) rdata = mask_q;
    for (int i = 0; i < NQ; i++)
      if (addr == q_ofs(i)) rdata = q_flat[32*i +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (|(gen_q & mask_q)) | (|q_flat);
  end
endmodule

// File: rtl/irq_reason_ctrl_chk.sv
module irq_reason_ctrl_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [31:0]   wdata,
  input logic [31:0]   rdata,
  input logic [31:0]   gen_evt,
  input logic [3:0]    rx_ctl,
  input logic [31:0]   gen_q,
  input logic [31:0]   mask_q,
  input logic [127:0]  q_flat,
  input logic          irq
);
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_evt != 0) |=> ((gen_q & $past(gen_evt)) == $past(gen_evt))); // R3
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    gen_q[11] |=> gen_q[11]); // R4
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h12C)) |=> (mask_q == $past(wdata))); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 0 && q_flat == 0) |=> !irq); // R5
  AST_Q1_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'('h28)) |-> ((rdata & ~32'h0000_DC00) == 0)); // R6
  AST_WA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q[8] |=> (q_flat[16] == $past(rx_ctl[0]))); // R8
endmodule

bind irq_reason_ctrl irq_reason_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .gen_evt(gen_evt), .rx_ctl(rx_ctl), .gen_q(gen_q),
  .mask_q(mask_q), .q_flat(q_flat), .irq(irq)
);

// File: tb/tb_irq_reason_ctrl.sv
`timescale 1ns/1ps
module tb_irq_reason_ctrl;
  logic clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic wr_en = 0, last_rx_done = 0;
  logic [31:0] wdata = '0, rdata, gen_evt = '0;
  logic [127:0] q_evt = '0;
  logic [3:0] rx_ctl = '0;
  logic irq;

  always #4 clk = ~clk;

  irq_reason_ctrl dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .gen_evt(gen_evt), .q_evt(q_evt),
    .rx_ctl(rx_ctl), .last_rx_done(last_rx_done), .irq(irq));

  localparam logic [11:0] IRQ_SEL = 12'hFFF;
  logic [11:0] sb_a[$];
  logic [31:0] sb_v[$];
  string       sb_t[$];
  int compared = 0, mismatched = 0;
  logic chk_req = 0, done = 0;

  task automatic chk(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    sb_a.push_back(a); sb_v.push_back(e); sb_t.push_back(t);
    if (a != IRQ_SEL) addr = a;
    chk_req = 1;
    @(negedge clk);
    chk_req = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    chk(IRQ_SEL, {31'b0, e}, t);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [31:0] ev);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1; gen_evt = ev;
    @(negedge clk);
    wr_en = 0; gen_evt = '0;
  endtask

  task automatic pulse_gen(input logic [31:0] v);
    @(negedge clk); gen_evt = v;
    @(negedge clk); gen_evt = '0;
  endtask

  task automatic pulse_q(input int i, input logic [31:0] v);
    @(negedge clk); q_evt[32*i +: 32] = v;
    @(negedge clk); q_evt = '0;
  endtask

  always @(negedge clk) begin
    #1;
    if (chk_req && sb_a.size() > 0) begin
      logic [11:0] a; logic [31:0] e, got; string t;
      a = sb_a.pop_front(); e = sb_v.pop_front(); t = sb_t.pop_front();
      got = (a == IRQ_SEL) ? {31'b0, irq} : rdata;
      compared++;
      if (got !== e) begin
        mismatched++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, a, got, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk(12'h128, 0, "R1"); chk(12'h12C, 0, "R1"); chk(12'h20, 0, "R1");
    chk(12'h38, 0, "R1"); chk_irq(0, "R1");
    pulse_gen(32'h2);
    chk(12'h128, 32'h2, "R3"); chk_irq(0, "R5");
    wr(12'h12C, 32'h2, 0);
    chk(12'h12C, 32'h2, "R5"); chk_irq(1, "R5");
    wr(12'h128, 32'h2, 0);
    chk(12'h128, 0, "R3"); chk_irq(0, "R3");
    wr(12'h128, 32'h1, 32'h1);
    chk(12'h128, 32'h1, "R3");
    pulse_gen(32'h800);
    wr(12'h128, 32'h801, 0);
    chk(12'h128, 32'h800, "R4");
    pulse_q(1, 32'hFFFF_FFFF);
    chk(12'h28, 32'h0000_DC00, "R6"); chk_irq(1, "R7");
    wr(12'h28, 32'hFFFF_FFFF, 0);
    chk(12'h28, 0, "R6");
    wr(12'h30, 32'hFFFF_FFFF, 0);
    chk(12'h30, 0, "R6"); chk_irq(0, "R7");
    @(negedge clk); rx_ctl[0] = 1;
    chk(12'h20, 32'h0001_0000, "R8"); chk(12'h38, 0, "R8"); chk(12'h28, 0, "R6");
    pulse_gen(32'h100);
    @(negedge clk); rx_ctl[0] = 0;
    chk(12'h20, 32'h0001_0000, "R8");
    wr(12'h20, 32'h0001_0000, 0);
    chk(12'h20, 0, "R8");
    pulse_q(0, 32'hFFFF_FFFF);
    chk(12'h20, 32'h0001_DC00, "R6");
    wr(12'h20, 32'hFFFF_FFFF, 0);
    chk(12'h20, 0, "R6");
    @(negedge clk); last_rx_done = 1;
    @(negedge clk); last_rx_done = 0;
    chk(12'h128, 32'h2000_0900, "R9");
    wr(12'h12C, 0, 0);
    chk_irq(0, "R5");
    wr(12'h12C, 32'h2000_0000, 0);
    chk_irq(1, "R5");
    wr(12'h124, 32'hFFFF_FFFF, 0);
    chk(12'h124, 0, "R2"); chk(12'h128, 32'h2000_0900, "R2");
    chk(12'h12C, 32'h2000_0000, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule